// File: doc/BRIEF.md
# Full-Bridge Drive Sequencer

This block is the digital controller of a self-oscillating full-bridge gate driver. An analog front end supplies digitized comparator flags. Two flags report the supply against an upper and a lower undervoltage level. Three flags report the timing ramp against 1/6, 1/3 and 2/3 of the supply. One flag reports the shutdown pin against its trip level. From these flags the block drives a charge/discharge command back to the ramp. It also produces the four gate enables of the bridge and a status code.

Operation follows a fixed sequence. After the supply comes up, both low-side switches conduct to charge the bootstrap capacitors. The two diagonal pairs then alternate, driven by the ramp crossings, with an all-off gap of a programmable number of cycles before each pair turns on. Two kinds of shutdown exist:
- A shutdown-pin fault is held until the supply collapses below the lower undervoltage level.
- Pulling the ramp below 1/6 of the supply only pauses the bridge. The bridge restarts through the precharge phase once the ramp is released.

Every flag passes through a synchronizer and a glitch filter before the state machine uses it.

Top module: `bridge_drive_seq`

## Requirements
- R1: After reset, and whenever the supply is below the upper level coming from the off state, status is 0 (off). All four gate enables are low and the ramp command is 0 (discharge).
- R2: Once running, the block returns to status 0 only when the filtered lower-level flag drops. A drop of the upper-level flag alone has no effect.
- R3: The supply rising above the upper level moves the block to status 1 (precharge). In precharge, lo1_o and lo2_o are high, hi1_o and hi2_o are low, and the ramp command is 1 (charge).
- R4: When the ramp reaches 1/3 in precharge, the first conduction phase is status 2 (lo1_o and hi2_o high, other two low). Phases then strictly alternate 2, 3, 2, 3, where status 3 drives lo2_o and hi1_o high and the other two low.
- R5: Every entry into a conduction phase is preceded by exactly DEAD_CYC cycles of status 4. During status 4 all four gate enables are low.
- R6: The ramp command is 1 in status 2 and 0 in status 3. Status 2 ends when the ramp reaches 2/3, and status 3 ends when the ramp falls below 1/3.
- R7: lo1_o and hi1_o are never high together, and lo2_o and hi2_o are never high together.
- R8: A filtered shutdown flag moves the block to status 5 (fault), with all enables low and the ramp command 0. Status 5 holds after the shutdown flag clears, and is left only through status 0 when the lower-level flag drops.
- R9: The ramp falling below 1/6 during conduction or the gap gives status 6 (paused). In status 6, lo1_o and lo2_o are high when PAUSE_LOW_ON=1 (the default), hi1_o and hi2_o are low, and the ramp command is 1. When the ramp rises past 1/6, the block re-enters status 1 and then sequences from status 2.
- R10: A flag pulse shorter than FILT_LEN cycles after synchronization is ignored; a one-cycle shutdown pulse does not cause status 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_hi_i | input | 1 | Supply above upper undervoltage level |
| vdd_lo_i | input | 1 | Supply above lower undervoltage level |
| ramp_sixth_i | input | 1 | Ramp above 1/6 supply |
| ramp_third_i | input | 1 | Ramp above 1/3 supply |
| ramp_two3_i | input | 1 | Ramp above 2/3 supply |
| sd_i | input | 1 | Shutdown pin above trip level |
| ramp_charge_o | output | 1 | Ramp command: 1 charge, 0 discharge |
| lo1_o | output | 1 | Low-side gate enable, leg 1 |
| lo2_o | output | 1 | Low-side gate enable, leg 2 |
| hi1_o | output | 1 | High-side gate enable, leg 1 |
| hi2_o | output | 1 | High-side gate enable, leg 2 |
| state_o | output | 3 | Status code 0..6 as defined in the requirements |

## Verification
The assertions assume consistent supply flags: the upper-level flag is never high while the lower-level flag is low. They also assume the ramp flags are ordered, so that above 2/3 implies above 1/3, which in turn implies above 1/6. The bench keeps within this by deriving the three ramp flags from one counter that follows the ramp command. It raises the lower supply flag before the upper and drops them in reverse order. The ramp counter is clamped and stepped slowly enough that, within the filter latency and the gap, it never overshoots past the next threshold unintentionally.

// File: rtl/bds_pkg.sv
`timescale 1ns/1ps
package bds_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PRE   = 3'd1,
    ST_RUNA  = 3'd2,
    ST_RUNB  = 3'd3,
    ST_GAP   = 3'd4,
    ST_FAULT = 3'd5,
    ST_PAUSE = 3'd6
  } seq_st_e;

  localparam int unsigned N_FLAGS = 6;
  localparam int unsigned FL_VHI  = 0;
  localparam int unsigned FL_VLO  = 1;
  localparam int unsigned FL_R6   = 2;
  localparam int unsigned FL_R3   = 3;
  localparam int unsigned FL_R23  = 4;
  localparam int unsigned FL_SD   = 5;
endpackage

// File: rtl/bds_sync_filt.sv
`timescale 1ns/1ps
module bds_sync_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= '0;
      q_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // output moves only when the whole window agrees
      if (&hist_q)       q_q <= 1'b1;
      else if (~|hist_q) q_q <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/bds_fsm.sv
`timescale 1ns/1ps
module bds_fsm
  import bds_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    vhi_i,
  input  logic    vlo_i,
  input  logic    r6_i,
  input  logic    r3_i,
  input  logic    r23_i,
  input  logic    sd_i,
  output seq_st_e st_o,
  output logic    chg_o
);
  localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);

  seq_st_e       st_q, st_d, nxt_q, nxt_d;
  logic          chg_q, chg_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    nxt_d = nxt_q;
    chg_d = chg_q;
    cnt_d = '0;
    if (st_q != ST_OFF && !vlo_i) begin
      st_d  = ST_OFF;
      chg_d = 1'b0;
    end else if (st_q != ST_OFF && st_q != ST_FAULT && sd_i) begin
      st_d  = ST_FAULT;
      chg_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          chg_d = 1'b0;
          if (vhi_i) begin
            st_d  = ST_PRE;
            chg_d = 1'b1;
          end
        end
        ST_PRE: begin
          chg_d = 1'b1;
          if (r3_i) begin
            st_d  = ST_GAP;
            nxt_d = ST_RUNA;
          end
        end
        ST_GAP: begin
          if (!r6_i) begin
            st_d  = ST_PAUSE;
            chg_d = 1'b1;
          end else if (cnt_q == CNT_LAST) begin
            st_d = nxt_q;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RUNA: begin
          if (!r6_i) begin
            st_d  = ST_PAUSE;
            chg_d = 1'b1;
          end else if (r23_i) begin
            st_d  = ST_GAP;
            nxt_d = ST_RUNB;
            chg_d = 1'b0;
          end
        end
        ST_RUNB: begin
          if (!r6_i) begin
            st_d  = ST_PAUSE;
            chg_d = 1'b1;
          end else if (!r3_i) begin
            st_d  = ST_GAP;
            nxt_d = ST_RUNA;
            chg_d = 1'b1;
          end
        end
        ST_FAULT: chg_d = 1'b0;
        ST_PAUSE: begin
          chg_d = 1'b1;
          if (r6_i) st_d = ST_PRE;
        end
        default: begin
          st_d  = ST_OFF;
          chg_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      nxt_q <= ST_RUNA;
      chg_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
      chg_q <= chg_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o  = st_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/bds_out.sv
`timescale 1ns/1ps
module bds_out
  import bds_pkg::*;
#(
  parameter bit PAUSE_LOW_ON = 1'b1
) (
  input  seq_st_e st_i,
  output logic    lo1_o,
  output logic    lo2_o,
  output logic    hi1_o,
  output logic    hi2_o
);
  logic pause_lo;

  generate
    if (PAUSE_LOW_ON) begin : g_pause_boot
      assign pause_lo = 1'b1;
    end else begin : g_pause_off
      assign pause_lo = 1'b0;
    end
  endgenerate

  always_comb begin
    lo1_o = 1'b0;
    lo2_o = 1'b0;
    hi1_o = 1'b0;
    hi2_o = 1'b0;
    unique case (st_i)
      ST_PRE: begin
        lo1_o = 1'b1;
        lo2_o = 1'b1;
      end
      ST_RUNA: begin
        lo1_o = 1'b1;
        hi2_o = 1'b1;
      end
      ST_RUNB: begin
        lo2_o = 1'b1;
        hi1_o = 1'b1;
      end
      ST_PAUSE: begin
        lo1_o = pause_lo;
        lo2_o = pause_lo;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bridge_drive_seq.sv
`timescale 1ns/1ps
module bridge_drive_seq
  import bds_pkg::*;
#(
  parameter int unsigned DEAD_CYC     = 100,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_LEN     = 2,
  parameter bit          PAUSE_LOW_ON = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vdd_hi_i,
  input  logic       vdd_lo_i,
  input  logic       ramp_sixth_i,
  input  logic       ramp_third_i,
  input  logic       ramp_two3_i,
  input  logic       sd_i,
  output logic       ramp_charge_o,
  output logic       lo1_o,
  output logic       lo2_o,
  output logic       hi1_o,
  output logic       hi2_o,
  output logic [2:0] state_o
);
  logic [N_FLAGS-1:0] raw_flags, flt_flags;
  seq_st_e            st;
  logic               vdd_lo_f;

  assign raw_flags[FL_VHI] = vdd_hi_i;
  assign raw_flags[FL_VLO] = vdd_lo_i;
  assign raw_flags[FL_R6]  = ramp_sixth_i;
  assign raw_flags[FL_R3]  = ramp_third_i;
  assign raw_flags[FL_R23] = ramp_two3_i;
  assign raw_flags[FL_SD]  = sd_i;

  generate
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flt
      bds_sync_filt #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
      ) i_filt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_flags[g]),
        .q_o   (flt_flags[g])
      );
    end
  endgenerate

  assign vdd_lo_f = flt_flags[FL_VLO];

  bds_fsm #(.DEAD_CYC(DEAD_CYC)) i_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vhi_i (flt_flags[FL_VHI]),
    .vlo_i (flt_flags[FL_VLO]),
    .r6_i  (flt_flags[FL_R6]),
    .r3_i  (flt_flags[FL_R3]),
    .r23_i (flt_flags[FL_R23]),
    .sd_i  (flt_flags[FL_SD]),
    .st_o  (st),
    .chg_o (ramp_charge_o)
  );

  bds_out #(.PAUSE_LOW_ON(PAUSE_LOW_ON)) i_out (
    .st_i (st),
    .lo1_o(lo1_o),
    .lo2_o(lo2_o),
    .hi1_o(hi1_o),
    .hi2_o(hi2_o)
  );

  assign state_o = st;
endmodule

// File: rtl/bds_chk.sv
`timescale 1ns/1ps
module bds_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lo1_o,
  input logic       lo2_o,
  input logic       hi1_o,
  input logic       hi2_o,
  input logic       ramp_charge_o,
  input logic [2:0] state_o,
  input logic       vdd_lo_f
);
  // R7
  no_shoot_leg1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo1_o && hi1_o));
  // R7
  no_shoot_leg2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo2_o && hi2_o));
  // R5
  gap_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |-> !(lo1_o || lo2_o || hi1_o || hi2_o));
  // R1
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |-> !(lo1_o || lo2_o || hi1_o || hi2_o || ramp_charge_o));
  // R3
  precharge_lows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1) |-> (lo1_o && lo2_o && !hi1_o && !hi2_o && ramp_charge_o));
  // R6
  run_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd3) |-> (ramp_charge_o == (state_o == 3'd2)));
  // R8
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && vdd_lo_f) |=> (state_o == 3'd5));
  // R4
  run_a_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |-> ($past(state_o) == 3'd4));
endmodule

bind bridge_drive_seq bds_chk i_bds_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lo1_o        (lo1_o),
  .lo2_o        (lo2_o),
  .hi1_o        (hi1_o),
  .hi2_o        (hi2_o),
  .ramp_charge_o(ramp_charge_o),
  .state_o      (state_o),
  .vdd_lo_f     (vdd_lo_f)
);

// File: tb/test_bridge_drive_seq.sv
`timescale 1ns/1ps
module test_bridge_drive_seq;
  localparam int DEAD = 6;
  localparam int T6 = 10, T3 = 20, T23 = 40, RMAX = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vhi = 1'b0, vlo = 1'b0, sd = 1'b0, pull_dn = 1'b0;
  logic chg, lo1, lo2, hi1, hi2;
  logic [2:0] st;
  int ramp = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bridge_drive_seq #(.DEAD_CYC(DEAD)) i_bridge_drive_seq (
    .clk_i(clk), .rst_ni(rst_n), .vdd_hi_i(vhi), .vdd_lo_i(vlo),
    .ramp_sixth_i(ramp >= T6), .ramp_third_i(ramp >= T3), .ramp_two3_i(ramp >= T23),
    .sd_i(sd), .ramp_charge_o(chg), .lo1_o(lo1), .lo2_o(lo2), .hi1_o(hi1),
    .hi2_o(hi2), .state_o(st));

  // ramp model: a clamped counter that follows the charge command
  always @(posedge clk) begin
    if (pull_dn) ramp <= 0;
    else if (chg && ramp < RMAX) ramp <= ramp + 1;
    else if (!chg && ramp > 0) ramp <= ramp - 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {lo1, lo2, hi1, hi2};
  endfunction

  task automatic wait_st(input int v, input int lim, input string req);
    int k = 0;
    while (st != v && k < lim) begin
      @(negedge clk);
      k++;
    end
    check(req, st, v);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // continuous monitor: gap length, alternation, exclusion, direction
  int gap_len = 0;
  int prev_run = 0;
  int prev_st = 0;
  int run_entries = 0;
  always @(negedge clk) if (rst_n) begin
    check("R7", int'((lo1 && hi1) || (lo2 && hi2)), 0);
    if (st == 4) begin
      gap_len++;
      check("R5", outs(), 0);
    end
    if ((st == 2 || st == 3) && prev_st == 4) begin
      check("R5", gap_len, DEAD);
      if (st == 2) check("R4", int'(prev_run == 3 || prev_run == 0), 1);
      else         check("R4", prev_run, 2);
      prev_run = st;
      run_entries++;
    end
    if (st != 4) gap_len = 0;
    if (st == 1) prev_run = 0;
    if (st == 2) check("R6", chg, 1);
    if (st == 3) check("R6", chg, 0);
    if (prev_st == 2 && st == 4) check("R6", int'(ramp >= T23), 1);
    if (prev_st == 3 && st == 4) check("R6", int'(ramp < T3), 1);
    prev_st = st;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check("R1", st, 0);
    check("R1", outs(), 0);
    rst_n = 1'b1;
    vlo = 1'b1;
    wait_cyc(40);
    check("R1", st, 0);
    check("R1", outs() | chg, 0);

    vhi = 1'b1;
    wait_st(1, 20, "R3");
    check("R3", outs(), 4'b1100);
    check("R3", chg, 1);
    wait_st(2, 200, "R4");
    check("R4", outs(), 4'b1001);
    wait_st(3, 300, "R4");
    check("R4", outs(), 4'b0110);
    wait_st(2, 300, "R4");
    wait_cyc(600);
    check("R4", int'(run_entries >= 8), 1);

    // hysteresis: upper flag alone
    vhi = 1'b0;
    wait_cyc(300);
    check("R2", int'(st >= 2 && st <= 4), 1);
    vlo = 1'b0;
    wait_st(0, 20, "R2");
    check("R2", outs() | chg, 0);
    vlo = 1'b1;
    wait_cyc(50);
    check("R1", st, 0);
    vhi = 1'b1;
    wait_st(1, 20, "R3");
    wait_st(3, 400, "R4");

    // one-cycle shutdown glitch is filtered
    @(negedge clk) sd = 1'b1;
    @(negedge clk) sd = 1'b0;
    wait_cyc(30);
    check("R10", int'(st != 5), 1);

    // latched shutdown
    sd = 1'b1;
    wait_st(5, 20, "R8");
    check("R8", outs() | chg, 0);
    sd = 1'b0;
    wait_cyc(400);
    check("R8", st, 5);
    check("R8", outs(), 0);
    vhi = 1'b0;
    vlo = 1'b0;
    wait_st(0, 20, "R8");
    vlo = 1'b1;
    vhi = 1'b1;
    wait_st(1, 20, "R8");
    wait_st(2, 200, "R8");

    // pause by ramp pull-down
    wait_cyc(150);
    pull_dn = 1'b1;
    wait_st(6, 30, "R9");
    check("R9", outs(), 4'b1100);
    check("R9", chg, 1);
    wait_cyc(100);
    check("R9", st, 6);
    pull_dn = 1'b0;
    wait_st(1, 40, "R9");
    wait_st(2, 200, "R9");
    wait_st(3, 300, "R9");
    wait_cyc(200);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule